// File: doc/BRIEF.md
# TDM Receive Slot Mask Controller

This block gates the receive side of a time-division-multiplexed serial port that runs in network mode, with up to 32 time slots per frame. The serial timing logic supplies a frame-sync strobe at the start of every frame and a slot-end strobe when each slot's word has been shifted in. The block counts slots from these strobes. For each slot it checks one bit of a 32-bit enable mask. An enabled slot's word is accepted: the data-full flag is set and, when enabled, an interrupt is raised. A disabled slot leaves the receive pin ignored and touches no flag.

Software programs the mask as two 16-bit halves over a 24-bit register bus. Half 0 covers slots 0 to 15 and half 1 covers slots 16 to 31. Writes go to a shadow copy. The shadow is copied into the active mask only on a frame-sync strobe, so a frame already in progress is never disturbed. Reading the receive data register clears the data-full flag. A separate strobe clears the overrun flag.

Top module: `rx_slot_gate`

## Requirements
- R1: `frame_sync_i` sets `slot_o` to 0 and `slot_valid_o` to 1 on the next cycle. Each `slot_end_i` in a valid frame advances `slot_o` by one. The `slot_end_i` for slot `frame_last_i` (or slot 31) drops `slot_valid_o`, and any later `slot_end_i` in the same frame is not accepted.
- R2: In the cycle where `slot_end_i` falls in a valid slot whose active mask bit is 1, `rx_accept_o` is 1 and `rx_pin_en_o` is 1. On the next cycle `rx_full_o` is 1.
- R3: In a valid slot whose active mask bit is 0, `rx_pin_en_o` and `rx_accept_o` stay 0. The slot-end then changes neither `rx_full_o` nor `rx_ovr_o`.
- R4: A mask write never changes gating in the current frame. The write takes effect at the next `frame_sync_i`. A write in the same cycle as `frame_sync_i` only takes effect at the frame sync after that.
- R5: `reg_wr_i` with `reg_sel_i`=0 stores `reg_wdata_i[15:0]` as slots 0–15. With `reg_sel_i`=1 it stores them as slots 16–31. Bits 23:16 of the write are dropped. `reg_rdata_o` returns the programmed half selected by `reg_sel_i`, with bits 23:16 equal to 0.
- R6: An accepted slot while `rx_full_o` is 1 and `rdr_read_i` is 0 sets `rx_ovr_o` on the next cycle, and `rx_full_o` stays 1.
- R7: `rdr_read_i` clears `rx_full_o` on the next cycle unless a slot is accepted in the same cycle; if both happen, setting wins. `ovr_clr_i` clears `rx_ovr_o` unless an overrun is set in the same cycle; if both happen, setting wins.
- R8: `irq_o` equals `rx_full_o` AND `irq_en_i`.
- R9: After `rst_ni` low, or one cycle after `soft_rst_i`: both mask halves read 0xFFFF, the active mask is all ones, `rx_full_o`, `rx_ovr_o` and `slot_valid_o` are 0, and `slot_o` is 0.
- R10: When `slot_end_i` and `frame_sync_i` come in the same cycle, the slot in progress is judged by the old active mask. The new frame then starts at slot 0 with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_wr_i | input | 1 | Mask half write strobe |
| reg_sel_i | input | 1 | Mask half select (0 low, 1 high) |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Selected mask half, zero-extended |
| frame_sync_i | input | 1 | Frame start strobe |
| slot_end_i | input | 1 | Slot completion strobe |
| frame_last_i | input | 5 | Index of the last slot in a frame |
| rdr_read_i | input | 1 | Receive data register read strobe |
| ovr_clr_i | input | 1 | Overrun clear strobe |
| irq_en_i | input | 1 | Receive interrupt enable |
| slot_o | output | 5 | Current slot number |
| slot_valid_o | output | 1 | A slot of the frame is in progress |
| rx_pin_en_o | output | 1 | Receive pin sampled in the current slot |
| rx_accept_o | output | 1 | Word of the completing slot is accepted |
| rx_full_o | output | 1 | Receive data full flag |
| rx_ovr_o | output | 1 | Receive overrun flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A corrupt active mask shows up in the same cycle as the wrong slot's `slot_end_i`: `rx_accept_o` disagrees with the bit the bench expects, and one cycle later `rx_full_o` disagrees too. A shadow copy that is loaded early or late shows up in the first slot after the mid-frame write or the next frame sync. A slot counter that drifts shows at `slot_o` and in the acceptance pattern of every later slot in the frame. Flag errors show up one cycle after the strobe that should have set or cleared the flag.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  typedef struct packed {
    logic full;
    logic ovr;
  } rx_flags_t;
endpackage

// File: rtl/rsg_mask_bank.sv
module rsg_mask_bank #(
  parameter int SLOTS  = 32,
  parameter int HALF_W = 16,
  parameter int BUS_W  = 24,
  localparam int NUM_HALF = SLOTS / HALF_W,
  localparam int SEL_W    = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             frame_sync_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [SLOTS-1:0] active_o
);
  logic [NUM_HALF-1:0][HALF_W-1:0] halves;
  logic [SLOTS-1:0]                shadow;
  logic [SLOTS-1:0]                active_q;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   half_q <= '1;
      else if (soft_rst_i)                           half_q <= '1;
      else if (wr_i && (sel_i == SEL_W'(h)))         half_q <= wdata_i[HALF_W-1:0];
    end
    assign halves[h]                   = half_q;
    assign shadow[h*HALF_W +: HALF_W]  = half_q;
  end

  // staged copy: only a frame boundary moves shadow into the gating path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           active_q <= '1;
    else if (soft_rst_i)   active_q <= '1;
    else if (frame_sync_i) active_q <= shadow;
  end

  always_comb begin
    rdata_o = '0;
    if (int'(sel_i) < NUM_HALF) rdata_o[HALF_W-1:0] = halves[sel_i];
  end

  assign active_o = active_q;
endmodule

// File: rtl/rsg_slot_track.sv
module rsg_slot_track #(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              frame_sync_i,
  input  logic              slot_end_i,
  input  logic [SLOT_W-1:0] frame_last_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              valid_q;
  logic              at_end;

  assign at_end = (slot_q >= frame_last_i) || (slot_q == TOP_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else if (soft_rst_i) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else if (frame_sync_i) begin
      slot_q  <= '0;
      valid_q <= 1'b1;
    end else if (slot_end_i && valid_q) begin
      if (at_end) valid_q <= 1'b0;
      else        slot_q  <= slot_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rsg_flags.sv
module rsg_flags
  import rsg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic accept_i,
  input  logic rdr_read_i,
  input  logic ovr_clr_i,
  input  logic irq_en_i,
  output logic full_o,
  output logic ovr_o,
  output logic irq_o
);
  rx_flags_t flags_q, flags_d;
  logic      ovr_set;

  // a read in the same cycle consumes the old word, so no overrun
  assign ovr_set = accept_i && flags_q.full && !rdr_read_i;

  always_comb begin
    flags_d = flags_q;
    if (accept_i)        flags_d.full = 1'b1;
    else if (rdr_read_i) flags_d.full = 1'b0;
    if (ovr_set)         flags_d.ovr  = 1'b1;
    else if (ovr_clr_i)  flags_d.ovr  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (soft_rst_i) flags_q <= '0;
    else                 flags_q <= flags_d;
  end

  assign full_o = flags_q.full;
  assign ovr_o  = flags_q.ovr;
  assign irq_o  = flags_q.full & irq_en_i;
endmodule

// File: rtl/rx_slot_gate.sv
module rx_slot_gate #(
  parameter int SLOTS  = 32,
  parameter int HALF_W = 16,
  parameter int BUS_W  = 24,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int NUM_HALF = SLOTS / HALF_W,
  localparam int SEL_W    = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_wr_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic              frame_sync_i,
  input  logic              slot_end_i,
  input  logic [SLOT_W-1:0] frame_last_i,
  input  logic              rdr_read_i,
  input  logic              ovr_clr_i,
  input  logic              irq_en_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_valid_o,
  output logic              rx_pin_en_o,
  output logic              rx_accept_o,
  output logic              rx_full_o,
  output logic              rx_ovr_o,
  output logic              irq_o
);
  logic [SLOTS-1:0]  active_mask;
  logic [SLOT_W-1:0] slot_cur;
  logic              slot_live;

  rsg_mask_bank #(.SLOTS(SLOTS), .HALF_W(HALF_W), .BUS_W(BUS_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .wr_i         (reg_wr_i),
    .sel_i        (reg_sel_i),
    .wdata_i      (reg_wdata_i),
    .frame_sync_i (frame_sync_i),
    .rdata_o      (reg_rdata_o),
    .active_o     (active_mask)
  );

  rsg_slot_track #(.SLOTS(SLOTS)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .frame_sync_i (frame_sync_i),
    .slot_end_i   (slot_end_i),
    .frame_last_i (frame_last_i),
    .slot_o       (slot_cur),
    .valid_o      (slot_live)
  );

  assign rx_pin_en_o = slot_live && active_mask[slot_cur];
  assign rx_accept_o = slot_end_i && rx_pin_en_o;

  rsg_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .accept_i   (rx_accept_o),
    .rdr_read_i (rdr_read_i),
    .ovr_clr_i  (ovr_clr_i),
    .irq_en_i   (irq_en_i),
    .full_o     (rx_full_o),
    .ovr_o      (rx_ovr_o),
    .irq_o      (irq_o)
  );

  assign slot_o       = slot_cur;
  assign slot_valid_o = slot_live;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int SLOTS  = 32,
  parameter int HALF_W = 16,
  parameter int BUS_W  = 24,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              frame_sync_i,
  input logic              slot_end_i,
  input logic [SLOT_W-1:0] frame_last_i,
  input logic [BUS_W-1:0]  reg_rdata_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              slot_valid_o,
  input logic              rx_accept_o,
  input logic              rx_full_o,
  input logic              rx_ovr_o,
  input logic              irq_o,
  input logic [SLOTS-1:0]  active_i
);
  a_r1_sync_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sync_i && !soft_rst_i) |=> (slot_o == '0) && slot_valid_o);

  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && !frame_sync_i && !soft_rst_i && slot_valid_o &&
     (slot_o < frame_last_i) && (slot_o != SLOT_W'(SLOTS - 1)))
    |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1)));

  a_r2_full_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_accept_o && !soft_rst_i) |=> rx_full_o);

  a_r3_full_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_accept_o |=> !$rose(rx_full_o));

  a_r3_ovr_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_accept_o |=> !$rose(rx_ovr_o));

  a_r4_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_sync_i && !soft_rst_i) |=> $stable(active_i));

  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[BUS_W-1:HALF_W] == '0);

  a_r6_ovr_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovr_o) |-> $past(rx_full_o));

  a_r8_irq_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_full_o);

  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (active_i == '1) && !rx_full_o && !rx_ovr_o && !slot_valid_o);
endmodule

bind rx_slot_gate rsg_checker #(.SLOTS(SLOTS), .HALF_W(HALF_W), .BUS_W(BUS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .frame_sync_i (frame_sync_i),
  .slot_end_i   (slot_end_i),
  .frame_last_i (frame_last_i),
  .reg_rdata_o  (reg_rdata_o),
  .slot_o       (slot_o),
  .slot_valid_o (slot_valid_o),
  .rx_accept_o  (rx_accept_o),
  .rx_full_o    (rx_full_o),
  .rx_ovr_o     (rx_ovr_o),
  .irq_o        (irq_o),
  .active_i     (active_mask)
);

// File: tb/sim_rx_slot_gate.sv
`timescale 1ns/1ps
module sim_rx_slot_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [0:0]  reg_sel = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        frame_sync = 1'b0;
  logic        slot_end = 1'b0;
  logic [4:0]  frame_last = 5'd31;
  logic        rdr_read = 1'b0;
  logic        ovr_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic [4:0]  slot;
  logic        slot_valid, pin_en, accept, full, ovr, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_slot_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .frame_sync_i(frame_sync), .slot_end_i(slot_end),
    .frame_last_i(frame_last), .rdr_read_i(rdr_read), .ovr_clr_i(ovr_clr),
    .irq_en_i(irq_en), .slot_o(slot), .slot_valid_o(slot_valid),
    .rx_pin_en_o(pin_en), .rx_accept_o(accept), .rx_full_o(full),
    .rx_ovr_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_half(input logic sel, input logic [23:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd_half(input string req, input logic sel, input logic [23:0] exp);
    reg_sel = sel;
    #2;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic do_sync();
    frame_sync = 1'b1;
    cyc();
    frame_sync = 1'b0;
    chk("R1 sync slot", 32'(slot), 32'd0);
    chk("R1 sync valid", 32'(slot_valid), 32'd1);
  endtask

  // one slot end; rd reads the data register in the same cycle
  task automatic do_slot(input string req, input logic rd, input logic exp_acc, input int s);
    slot_end = 1'b1; rdr_read = rd;
    #2;
    chk(req, 32'(accept), 32'(exp_acc));
    chk(req, 32'(pin_en), 32'(exp_acc));
    chk("R1 slot index", 32'(slot), 32'(s));
    cyc();
    slot_end = 1'b0; rdr_read = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int f);
    return (32'h9E3779B9 * 32'(f + 3)) ^ (32'hFFFF_FFFF << f);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m_cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R9 hardware reset state
    rd_half("R9 reset low", 1'b0, 24'h00FFFF);
    rd_half("R9 reset high", 1'b1, 24'h00FFFF);
    chk("R9 reset full", 32'(full), 0);
    chk("R9 reset ovr", 32'(ovr), 0);
    chk("R9 reset valid", 32'(slot_valid), 0);
    chk("R9 reset slot", 32'(slot), 0);

    // R5 readback, upper write bits dropped
    wr_half(1'b0, 24'hAB1234);
    wr_half(1'b1, 24'hFF5678);
    rd_half("R5 low", 1'b0, 24'h001234);
    rd_half("R5 high", 1'b1, 24'h005678);

    // sweep frames, mask for the next frame written mid-frame
    m_cur = pat(0);
    wr_half(1'b0, {8'hC3, m_cur[15:0]});
    wr_half(1'b1, {8'h5A, m_cur[31:16]});
    for (int f = 0; f < 6; f++) begin
      logic [31:0] m_nxt;
      int last;
      m_nxt = pat(f + 1);
      last = (f == 0) ? 31 : (f * 13 + 7) % 32;
      frame_last = 5'(last);
      do_sync();
      for (int s = 0; s <= last; s++) begin
        if (s == 1) begin
          wr_half(1'b0, {8'h00, m_nxt[15:0]});
          wr_half(1'b1, {8'h00, m_nxt[31:16]});
        end
        do_slot(s >= 2 ? "R4 staged" : (m_cur[s] ? "R2 enabled" : "R3 masked"),
                1'b1, m_cur[s], s);
        chk(m_cur[s] ? "R2 full" : "R3 no full", 32'(full), 32'(m_cur[s]));
        chk("R3 no ovr", 32'(ovr), 0);
      end
      chk("R1 frame ended", 32'(slot_valid), 0);
      slot_end = 1'b1;
      #2;
      chk("R1 beyond frame", 32'(accept), 0);
      cyc();
      slot_end = 1'b0;
      m_cur = m_nxt;
    end

    // R4 write in the sync cycle waits one more frame
    frame_last = 5'd31;
    wr_half(1'b0, 24'h00FFFF);
    wr_half(1'b1, 24'h00FFFF);
    do_sync();
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 24'h000000; frame_sync = 1'b1;
    cyc();
    reg_wr = 1'b0; frame_sync = 1'b0;
    do_slot("R4 sync-cycle write", 1'b1, 1'b1, 0);
    do_sync();
    do_slot("R4 applied next frame", 1'b1, 1'b0, 0);

    // R10 slot end with frame sync: old mask judges, new frame at slot 0
    wr_half(1'b0, 24'h00FFFF);
    slot_end = 1'b1; frame_sync = 1'b1; rdr_read = 1'b1;
    #2;
    chk("R10 old mask", 32'(accept), 0);
    cyc();
    slot_end = 1'b0; frame_sync = 1'b0; rdr_read = 1'b0;
    chk("R10 slot reset", 32'(slot), 0);
    chk("R10 valid", 32'(slot_valid), 1);
    do_slot("R10 new mask", 1'b1, 1'b1, 0);

    // R6 R7 R8 R3 flag behaviour
    wr_half(1'b0, 24'h00FFFB);
    do_sync();
    rdr_read = 1'b1; cyc(); rdr_read = 1'b0;
    chk("R7 read clears", 32'(full), 0);
    do_slot("R2 slot0", 1'b0, 1'b1, 0);
    chk("R2 full set", 32'(full), 1);
    irq_en = 1'b1; #1;
    chk("R8 irq on", 32'(irq), 1);
    irq_en = 1'b0; #1;
    chk("R8 irq masked", 32'(irq), 0);
    do_slot("R7 accept beats read", 1'b1, 1'b1, 1);
    chk("R7 full kept", 32'(full), 1);
    chk("R7 no ovr on read", 32'(ovr), 0);
    do_slot("R3 masked while full", 1'b0, 1'b0, 2);
    chk("R3 full unchanged", 32'(full), 1);
    chk("R3 ovr unchanged", 32'(ovr), 0);
    do_slot("R6 overrun slot", 1'b0, 1'b1, 3);
    chk("R6 ovr set", 32'(ovr), 1);
    chk("R6 full stays", 32'(full), 1);
    ovr_clr = 1'b1; slot_end = 1'b1;
    cyc();
    ovr_clr = 1'b0; slot_end = 1'b0;
    chk("R7 ovr set beats clear", 32'(ovr), 1);
    ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
    chk("R7 ovr clear", 32'(ovr), 0);
    rdr_read = 1'b1; cyc(); rdr_read = 1'b0;
    chk("R7 full clear", 32'(full), 0);
    irq_en = 1'b1; #1;
    chk("R8 irq idle", 32'(irq), 0);
    irq_en = 1'b0;

    // R9 soft reset
    wr_half(1'b0, 24'h000000);
    wr_half(1'b1, 24'h000000);
    do_sync();
    do_slot("R9 pre", 1'b0, 1'b0, 0);
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
    rd_half("R9 soft low", 1'b0, 24'h00FFFF);
    rd_half("R9 soft high", 1'b1, 24'h00FFFF);
    chk("R9 soft valid", 32'(slot_valid), 0);
    chk("R9 soft full", 32'(full), 0);
    slot_end = 1'b1; frame_sync = 1'b1;
    cyc();
    slot_end = 1'b0; frame_sync = 1'b0;
    do_slot("R9 active all ones", 1'b1, 1'b1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule